// File: doc/BRIEF.md
# Cache Way Fault Test and ECC Pairing Controller

This block serves one set of a multi-way cache run at a reduced supply level. On a start pulse it runs a pattern test through a simple way read/write port. Every word of every way is written with all zeros and read back, and then the same is done with all ones. Any word that reads back wrong marks its way as faulty. The fault flags are sticky for the whole test.

Once the test is over, the block combines the fault flags with a per-way correctability input supplied by the codec check. From these it derives a configuration for the set that keeps as much capacity as it can:

- A clean way is used as is, and the codec is bypassed for it.
- Correctable faulty ways are paired up. The lower-numbered way of each pair holds the data and the higher-numbered way holds the check bits.
- A faulty way left over without a partner is switched off.
- A way the code cannot repair is switched off.

The configuration holds a 2-bit role and a 2-bit partner index for each way. It is held in registers until the next test. A one-cycle done pulse follows the moment the configuration becomes stable.

Top module: `way_pair_ctrl`

## Requirements
- R1: After start, the block writes every word of every way with all zeros, then reads all of them back. It then writes every word with all ones and reads all of them back. That is NUM_WAYS*WORDS writes of zeros and the same number of writes of ones, with no zero write after the first ones write, and 2*NUM_WAYS*WORDS reads. Read data is expected one cycle after a read is issued.
- R2: A read-back word that differs from the pattern written marks its way faulty. This holds for a bit stuck at 0 (seen in the ones pass) and for a bit stuck at 1 (seen in the zeros pass).
- R3: A way with no fault gets role 0 (clean), its own index as partner, and its cfg_bypass bit set. Role codes are: 0 clean, 1 data, 2 check bits, 3 off. Way i owns cfg_role[2i+1:2i] and cfg_partner[2i+1:2i].
- R4: When exactly one correctable faulty way exists, it gets role 3 with its own index as partner.
- R5: Correctable faulty ways are paired lowest index first. The lower way of a pair gets role 1 and the higher way gets role 2. Each names the other as partner.
- R6: With three correctable faulty ways, the two lowest are paired per R5 and the highest gets role 3 with itself as partner.
- R7: With four correctable faulty ways, ways 0 and 1 form one pair and ways 2 and 3 form another, each per R5.
- R8: A faulty way whose correctability input is low gets role 3 with itself as partner. It takes no part in pairing, whatever the other ways are.
- R9: done is high for exactly one cycle. The configuration is already final in that cycle and does not change until a later test.
- R10: A start pulse while a test is running is ignored. The test continues, with no extra accesses and no extra done.
- R11: After reset, all roles are 0, every partner is its own index, done is low, and no access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test (ignored when busy) |
| mem_en | output | 1 | Way access valid |
| mem_we | output | 1 | Access is a write |
| mem_way | output | WAY_W | Way being accessed |
| mem_addr | output | ADR_W | Word within the way |
| mem_wdata | output | DATA_W | Test pattern |
| mem_rdata | input | DATA_W | Read data, one cycle after a read |
| way_correctable | input | NUM_WAYS | Per-way: faults are within code strength |
| done | output | 1 | One-cycle pulse, configuration ready |
| cfg_role | output | 2*NUM_WAYS | Packed per-way role codes |
| cfg_partner | output | WAY_W*NUM_WAYS | Packed per-way partner index |
| cfg_bypass | output | NUM_WAYS | Per-way codec bypass (clean way) |

## Verification
The hardest cases to reach are the mixed sets, where correctable and uncorrectable faulty ways interleave. An uncorrectable way in the middle must not break up the lowest-first pairing of the ways around it. The stimulus sweeps every combination of faulty-way mask and correctability mask. Faults are injected in a memory model as single stuck bits, alternating stuck-at-0 and stuck-at-1 across words and bit positions, so both passes of the test get to detect them. Some runs also pulse start again in the middle of the write pass to show that a test cannot be restarted while it is running.

// File: rtl/way_pair_pkg.sv
package way_pair_pkg;
   typedef enum logic [1:0] {
      ROLE_CLEAN = 2'd0,
      ROLE_DATA  = 2'd1,
      ROLE_ECC   = 2'd2,
      ROLE_OFF   = 2'd3
   } way_role_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_WR0,
      PH_RD0,
      PH_WR1,
      PH_RD1,
      PH_DRAIN,
      PH_LOAD,
      PH_DONE
   } march_ph_e;
endpackage

// File: rtl/way_pair_march.sv
module way_pair_march
   import way_pair_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   parameter int WORDS    = 4,
   parameter int DATA_W   = 8,
   localparam int WAY_W   = $clog2(NUM_WAYS),
   localparam int ADR_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              mem_en,
   output logic              mem_we,
   output logic [WAY_W-1:0]  mem_way,
   output logic [ADR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              chk_en,
   output logic              chk_pat,
   output logic              clr,
   output logic              cfg_load,
   output logic              done_o
);
   localparam int SLOTS = NUM_WAYS * WORDS;
   localparam int CNT_W = $clog2(SLOTS);

   march_ph_e        ph;
   logic [CNT_W-1:0] cnt;
   logic             last;
   logic             in_acc;
   logic             ones;

   assign last   = (cnt == CNT_W'(SLOTS - 1));
   assign in_acc = (ph == PH_WR0) || (ph == PH_RD0) || (ph == PH_WR1) || (ph == PH_RD1);
   assign ones   = (ph == PH_WR1) || (ph == PH_RD1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else begin
         case (ph)
            PH_IDLE:  if (start) ph <= PH_WR0;
            PH_WR0:   if (last) ph <= PH_RD0;
            PH_RD0:   if (last) ph <= PH_WR1;
            PH_WR1:   if (last) ph <= PH_RD1;
            PH_RD1:   if (last) ph <= PH_DRAIN;
            PH_DRAIN: ph <= PH_LOAD;
            PH_LOAD:  ph <= PH_DONE;
            default:  ph <= PH_IDLE;
         endcase
         if (ph == PH_IDLE)
            cnt <= '0;
         else if (in_acc)
            cnt <= last ? '0 : cnt + 1'b1;
      end
   end

   assign mem_en    = in_acc;
   assign mem_we    = (ph == PH_WR0) || (ph == PH_WR1);
   assign mem_way   = WAY_W'(cnt / CNT_W'(WORDS));
   assign mem_addr  = ADR_W'(cnt % CNT_W'(WORDS));
   assign mem_wdata = {DATA_W{ones}};
   assign chk_en    = (ph == PH_RD0) || (ph == PH_RD1);
   assign chk_pat   = ones;
   assign clr       = (ph == PH_IDLE) && start;
   assign cfg_load  = (ph == PH_LOAD);
   assign done_o    = (ph == PH_DONE);

   // R10
   restart_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != PH_IDLE && start) |=> !(ph == PH_WR0 && cnt == '0));

   // R1
   ones_after_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && mem_wdata == '0) |=> !(mem_en && !mem_we && chk_pat));
endmodule

// File: rtl/way_pair_flags.sv
module way_pair_flags #(
   parameter int NUM_WAYS = 4,
   parameter int DATA_W   = 8,
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                chk_en,
   input  logic                chk_pat,
   input  logic [WAY_W-1:0]    chk_way,
   input  logic [DATA_W-1:0]   rdata,
   output logic [NUM_WAYS-1:0] fail
);
   logic             pend_vld;
   logic             pend_pat;
   logic [WAY_W-1:0] pend_way;
   logic             miss;

   assign miss = pend_vld && (rdata != {DATA_W{pend_pat}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld <= 1'b0;
         pend_pat <= 1'b0;
         pend_way <= '0;
         fail     <= '0;
      end else begin
         pend_vld <= chk_en;
         pend_pat <= chk_pat;
         pend_way <= chk_way;
         if (clr)
            fail <= '0;
         else if (miss)
            fail[pend_way] <= 1'b1;
      end
   end

   // R2
   fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((fail & $past(fail)) == $past(fail)));
endmodule

// File: rtl/way_pair_alloc.sv
module way_pair_alloc
   import way_pair_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   localparam int WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic [NUM_WAYS-1:0]             fail,
   input  logic [NUM_WAYS-1:0]             corr,
   output logic [NUM_WAYS-1:0][1:0]        role,
   output logic [NUM_WAYS-1:0][WAY_W-1:0]  partner
);
   logic             pend_vld;
   logic [WAY_W-1:0] pend;

   always_comb begin
      pend_vld = 1'b0;
      pend     = '0;
      for (int i = 0; i < NUM_WAYS; i++) begin
         role[i]    = ROLE_CLEAN;
         partner[i] = WAY_W'(i);
      end
      for (int i = 0; i < NUM_WAYS; i++) begin
         if (fail[i]) begin
            if (!corr[i]) begin
               role[i] = ROLE_OFF;
            end else if (!pend_vld) begin
               role[i]  = ROLE_OFF;
               pend     = WAY_W'(i);
               pend_vld = 1'b1;
            end else begin
               role[pend]    = ROLE_DATA;
               partner[pend] = WAY_W'(i);
               role[i]       = ROLE_ECC;
               partner[i]    = pend;
               pend_vld      = 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/way_pair_ctrl.sv
module way_pair_ctrl
   import way_pair_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   parameter int WORDS    = 4,
   parameter int DATA_W   = 8,
   localparam int WAY_W   = $clog2(NUM_WAYS),
   localparam int ADR_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   output logic                      mem_en,
   output logic                      mem_we,
   output logic [WAY_W-1:0]          mem_way,
   output logic [ADR_W-1:0]          mem_addr,
   output logic [DATA_W-1:0]         mem_wdata,
   input  logic [DATA_W-1:0]         mem_rdata,
   input  logic [NUM_WAYS-1:0]       way_correctable,
   output logic                      done,
   output logic [2*NUM_WAYS-1:0]     cfg_role,
   output logic [WAY_W*NUM_WAYS-1:0] cfg_partner,
   output logic [NUM_WAYS-1:0]       cfg_bypass
);
   if (NUM_WAYS < 2) begin : g_bad_ways
      $error("way_pair_ctrl: NUM_WAYS must be at least 2");
   end
   if (WORDS < 1 || DATA_W < 1) begin : g_bad_size
      $error("way_pair_ctrl: WORDS and DATA_W must be positive");
   end

   logic                             chk_en, chk_pat, clr, cfg_load;
   logic [NUM_WAYS-1:0]              fail;
   logic [NUM_WAYS-1:0][1:0]         role_d, role_q;
   logic [NUM_WAYS-1:0][WAY_W-1:0]   part_d, part_q;

   way_pair_march #(.NUM_WAYS(NUM_WAYS), .WORDS(WORDS), .DATA_W(DATA_W)) u_march (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mem_en(mem_en), .mem_we(mem_we), .mem_way(mem_way), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .chk_en(chk_en), .chk_pat(chk_pat), .clr(clr),
      .cfg_load(cfg_load), .done_o(done)
   );

   way_pair_flags #(.NUM_WAYS(NUM_WAYS), .DATA_W(DATA_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .clr(clr), .chk_en(chk_en), .chk_pat(chk_pat),
      .chk_way(mem_way), .rdata(mem_rdata), .fail(fail)
   );

   way_pair_alloc #(.NUM_WAYS(NUM_WAYS)) u_alloc (
      .fail(fail), .corr(way_correctable), .role(role_d), .partner(part_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WAYS; i++) begin
            role_q[i] <= ROLE_CLEAN;
            part_q[i] <= WAY_W'(i);
         end
      end else if (cfg_load) begin
         role_q <= role_d;
         part_q <= part_d;
      end
   end

   assign cfg_role    = role_q;
   assign cfg_partner = part_q;

   for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
      assign cfg_bypass[g] = (role_q[g] == ROLE_CLEAN);

      // R5
      pair_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (role_q[g] == ROLE_DATA) |-> (role_q[part_q[g]] == ROLE_ECC && part_q[part_q[g]] == WAY_W'(g)));

      // R8
      weak_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_load && fail[g] && !way_correctable[g]) |=> (role_q[g] == ROLE_OFF));

      // R3
      clean_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_load && !fail[g]) |=> (role_q[g] == ROLE_CLEAN && cfg_bypass[g]));
   end

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ($stable(cfg_role) && $stable(cfg_partner)));
endmodule

// File: tb/way_pair_ctrl_tb.sv
module way_pair_ctrl_tb;
   localparam int NW = 4, WD = 4, DW = 8, WW = 2, AW = 2;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic mem_en, mem_we, done;
   logic [WW-1:0] mem_way;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, rdata_q;
   logic [NW-1:0] corr, cfg_bypass;
   logic [2*NW-1:0] cfg_role;
   logic [WW*NW-1:0] cfg_partner;

   always #4 clk = ~clk;

   way_pair_ctrl #(.NUM_WAYS(NW), .WORDS(WD), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_en(mem_en), .mem_we(mem_we),
      .mem_way(mem_way), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rdata_q),
      .way_correctable(corr), .done(done), .cfg_role(cfg_role),
      .cfg_partner(cfg_partner), .cfg_bypass(cfg_bypass)
   );

   logic [DW-1:0] mem [NW][WD];
   logic [DW-1:0] s0 [NW][WD];
   logic [DW-1:0] s1 [NW][WD];

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem[mem_way][mem_addr] <= mem_wdata;
         else rdata_q <= (mem[mem_way][mem_addr] & ~s0[mem_way][mem_addr]) | s1[mem_way][mem_addr];
      end
   end

   int nwz, nwo, nrd, ndone;
   bit seen_one, order_bad;
   always @(posedge clk) begin
      if (rst_n) begin
         if (mem_en && mem_we) begin
            if (mem_wdata == '0) begin nwz++; if (seen_one) order_bad = 1; end
            else if (mem_wdata == '1) begin nwo++; seen_one = 1; end
         end
         if (mem_en && !mem_we) nrd++;
         if (done) ndone++;
      end
   end

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int erole [NW];
      int epart [NW];
      string etag [NW];
      int elig [NW];
      logic [2*NW-1:0] snap_role;
      logic [WW*NW-1:0] snap_part;
      int ne, p, run, k, bitp, wd;
      rdata_q = '0;
      corr = '0;
      for (int w = 0; w < NW; w++)
         for (int a = 0; a < WD; a++) begin
            mem[w][a] = '0; s0[w][a] = '0; s1[w][a] = '0;
         end
      repeat (3) @(negedge clk);
      chk(cfg_role == '0, "R11", "reset roles", int'(cfg_role), 0);
      chk(cfg_partner == 8'b11_10_01_00, "R11", "reset partners", int'(cfg_partner), 8'he4);
      chk(!done && !mem_en, "R11", "reset done/mem_en", int'({done, mem_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int f = 0; f < 16; f++) begin
         for (int c = 0; c < 16; c++) begin
            run = f * 16 + c;
            for (int w = 0; w < NW; w++)
               for (int a = 0; a < WD; a++) begin
                  s0[w][a] = '0; s1[w][a] = '0;
               end
            for (int w = 0; w < NW; w++) begin
               if (f[w]) begin
                  wd = (w + run) % WD;
                  bitp = (w + run) % DW;
                  if (((w + run) % 2) == 1) s1[w][wd][bitp] = 1'b1;
                  else s0[w][wd][bitp] = 1'b1;
               end
            end
            corr = c[NW-1:0];
            nwz = 0; nwo = 0; nrd = 0; ndone = 0; seen_one = 0; order_bad = 0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (run % 5 == 0) begin
               repeat (10) @(negedge clk);
               start = 1'b1;
               @(negedge clk);
               start = 1'b0;
            end
            k = 0;
            while (!done && k < 400) begin
               @(negedge clk);
               k++;
            end
            chk(done == 1'b1, "R9", "done seen", int'(done), 1);

            ne = 0;
            for (int w = 0; w < NW; w++)
               if (f[w] && c[w]) begin elig[ne] = w; ne++; end
            for (int w = 0; w < NW; w++) begin
               if (!f[w]) begin
                  erole[w] = 0; epart[w] = w; etag[w] = "R3";
               end else if (!c[w]) begin
                  erole[w] = 3; epart[w] = w; etag[w] = "R2 R8";
               end else begin
                  p = 0;
                  for (int q = 0; q < ne; q++) if (elig[q] == w) p = q;
                  if (p == ne - 1 && (ne % 2) == 1) begin
                     erole[w] = 3; epart[w] = w; etag[w] = (ne == 1) ? "R2 R4" : "R2 R6";
                  end else begin
                     if ((p % 2) == 0) begin erole[w] = 1; epart[w] = elig[p+1]; end
                     else begin erole[w] = 2; epart[w] = elig[p-1]; end
                     etag[w] = (ne == 2) ? "R2 R5" : (ne == 3) ? "R2 R6" : "R2 R7";
                  end
               end
               chk(int'(cfg_role[2*w +: 2]) == erole[w], etag[w],
                   $sformatf("run %0d way %0d role", run, w), int'(cfg_role[2*w +: 2]), erole[w]);
               chk(int'(cfg_partner[WW*w +: WW]) == epart[w], etag[w],
                   $sformatf("run %0d way %0d partner", run, w), int'(cfg_partner[WW*w +: WW]), epart[w]);
               chk(cfg_bypass[w] == (erole[w] == 0), "R3",
                   $sformatf("run %0d way %0d bypass", run, w), int'(cfg_bypass[w]), int'(erole[w] == 0));
            end
            snap_role = cfg_role;
            snap_part = cfg_partner;
            @(negedge clk);
            chk(!done, "R9", "done one cycle", int'(done), 0);
            repeat (3) @(negedge clk);
            chk(cfg_role == snap_role && cfg_partner == snap_part, "R9", "config held",
                int'({cfg_role, cfg_partner}), int'({snap_role, snap_part}));
            chk(ndone == 1, "R10", $sformatf("run %0d done count", run), ndone, 1);
            chk(nwz == NW * WD && nwo == NW * WD, "R1", "pattern writes", nwz + nwo, 2 * NW * WD);
            chk(nrd == 2 * NW * WD, "R1", "reads", nrd, 2 * NW * WD);
            chk(!order_bad, "R1", "zeros before ones", int'(order_bad), 0);
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule